// File: doc/BRIEF.md
# Serial Bus Byte Shifter with Slave Address Compare

This block moves one byte at a time over a single shared open-drain data line. An external serial clock paces it. On each falling clock edge the next outgoing bit, most significant first, goes into an output latch. On each rising edge the level actually present on the line is shifted into the low end of the shift register. A host writes the shift register to start a transfer. Because the line is read back, the register holds what the bus really carried when the transfer ends, whichever device drove it. To receive, the host writes all ones, which releases the line on every bit.

A slave address register is compared with the shift register all the time, and the result is shown on a match output. The comparison serves two purposes. In wake-up mode it selects the slave: the completion interrupt is raised only when the first byte after a bus-release pulse equals the stored address. It also checks a transmission: the host loads the same byte into both registers and sends it, and a match of 0 afterwards means another device pulled the line low.

Top module: `sbus_shifter`

## Requirements
- R1: After reset the shift register and the address register read 0, busy is 0, irq is 0 and the data line is released (`sdata_drive_low` = 0).
- R2: A host write with `host_sel` = 0 loads the shift register, sets busy and restarts the bit count, even in the middle of a transfer. A write with `host_sel` = 1 loads the address register. `host_rdata` shows the shift register when `host_sel` = 0 and the address register when it is 1.
- R3: During a transfer each falling edge of `sclk` loads the current bit 7 of the shift register into the output latch, so bits leave most significant first. `sdata_drive_low` is 1 exactly when that latch holds 0.
- R4: During a transfer each rising edge of `sclk` shifts the register left and takes the `sdata_in` level into bit 0. The partly shifted value can be read at any time.
- R5: The eighth rising edge after a start clears busy and releases the line.
- R6: `match` is 1 exactly when the shift register equals the address register.
- R7: With `wake_en` = 0, irq is high for exactly one cycle, in the cycle after the eighth rising edge is taken, for every completed byte.
- R8: With `wake_en` = 1, irq is raised only when the completed byte equals the address register and it is the first byte completed after a `bus_rel` pulse. Otherwise no irq is raised.
- R9: If another device pulls the line low while this block sends a 1, the read-back byte differs from the byte sent. With the same byte loaded into both registers, `match` then reads 0.
- R10: `sclk` edges while the block is not busy leave the shift register and the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 shift register, 1 address register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register contents |
| wake_en | input | 1 | Wake-up mode: irq only on an address match |
| bus_rel | input | 1 | Pulse marking a bus release; arms the address check |
| sclk | input | 1 | Serial clock, sampled on clk, idles high |
| sdata_in | input | 1 | Level present on the shared data line |
| sdata_drive_low | output | 1 | Pull the data line low when 1 |
| match | output | 1 | Shift register equals address register |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A behavioural model of the bus, the line included, is compared with every output on every cycle while the bench sends, receives and collides on the line. It targets a conflicting device that pulls a transmitted 1 low: a design that shifted its own latch instead of the line would still report a match. Wake-up receives are run with and without a preceding bus release and with a wrong address, so an irq that is not gated, or a bus-release arm that is never cleared, shows up as an extra pulse. A read after four bits and `sclk` toggling while idle catch a register that does not shift with the line or that keeps shifting once the transfer is over.

// File: rtl/sbus_shifter.sv
module sbus_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_wr,
  input  logic         host_sel,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  input  logic         wake_en,
  input  logic         bus_rel,
  input  logic         sclk,
  input  logic         sdata_in,
  output logic         sdata_drive_low,
  output logic         match,
  output logic         busy,
  output logic         irq
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr, sva;
  logic [CW-1:0] cnt;
  logic          sclk_q, olat, armed;

  wire rise   = sclk & ~sclk_q;
  wire fall   = ~sclk & sclk_q;
  wire wr_sr  = host_wr & ~host_sel;
  wire wr_sva = host_wr & host_sel;
  wire [W-1:0] sr_nxt = {sr[W-2:0], sdata_in};
  wire last   = busy & rise & ~wr_sr & (cnt == LAST);

  assign host_rdata      = host_sel ? sva : sr;
  assign match           = (sr == sva);
  assign sdata_drive_low = ~olat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      sva    <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      olat   <= 1'b1;
      armed  <= 1'b0;
      irq    <= 1'b0;
      sclk_q <= 1'b1;
    end else begin
      sclk_q <= sclk;
      irq    <= last & (~wake_en | (armed & (sr_nxt == sva)));
      armed  <= bus_rel | (armed & ~last);
      if (wr_sva) sva <= host_wdata;
      if (wr_sr) begin
        sr   <= host_wdata;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (fall) olat <= sr[W-1];
        if (rise) begin
          sr  <= sr_nxt;
          cnt <= cnt + 1'b1;
        end
        if (last) begin
          busy <= 1'b0;
          olat <= 1'b1;
        end
      end
    end
  end

  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdata_drive_low);

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(busy));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_sr) |=> (sr == $past(sr)));

  p_wake_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(wake_en) && !$past(host_wr)) |-> match);

endmodule

// File: tb/sbus_shifter_tb.sv
module sbus_shifter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_sel = 0, wake_en = 0, bus_rel = 0, sclk = 1, ext_low = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic sdata_drive_low, match, busy, irq;
  wire  sdata_in = ~(sdata_drive_low | ext_low);

  int checks = 0, errors = 0, irq_seen = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sbus_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .wake_en(wake_en),
    .bus_rel(bus_rel), .sclk(sclk), .sdata_in(sdata_in),
    .sdata_drive_low(sdata_drive_low), .match(match), .busy(busy), .irq(irq)
  );

  // behavioural reference
  logic [7:0] m_sr = 0, m_sva = 0;
  int  m_bits = 0;
  bit  m_busy = 0, m_lat = 1, m_irq = 0, m_armed = 0, m_prev = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr = 0; m_sva = 0; m_bits = 0; m_busy = 0; m_lat = 1;
      m_irq = 0; m_armed = 0; m_prev = 1;
    end else begin
      bit r, f, line, fin, old_armed;
      logic [7:0] old_sva;
      r = sclk && !m_prev;
      f = !sclk && m_prev;
      m_prev = sclk;
      line = m_lat && !ext_low;
      old_sva = m_sva;
      old_armed = m_armed;
      fin = 0;
      if (host_wr && host_sel) m_sva = host_wdata;
      if (host_wr && !host_sel) begin
        m_sr = host_wdata; m_busy = 1; m_bits = 0;
      end else if (m_busy) begin
        if (f) m_lat = m_sr[7];
        if (r) begin
          m_sr = {m_sr[6:0], line};
          m_bits++;
          if (m_bits == 8) begin
            fin = 1; m_busy = 0; m_lat = 1;
          end
        end
      end
      m_irq = fin && (!wake_en || (old_armed && m_sr == old_sva));
      m_armed = bus_rel || (old_armed && !fin);
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R3 line drive", {7'd0, sdata_drive_low}, {7'd0, !m_lat});
    chk("R2/R4 read data", host_rdata, host_sel ? m_sva : m_sr);
    chk("R6 match", {7'd0, match}, {7'd0, m_sr == m_sva});
    chk("R5 busy", {7'd0, busy}, {7'd0, m_busy});
    chk("R7/R8 irq", {7'd0, irq}, {7'd0, m_irq});
    if (irq) irq_seen++;
    host_wr = 0; bus_rel = 0;
  endtask

  task automatic hwrite(bit sel, logic [7:0] d);
    host_sel = sel; host_wdata = d; host_wr = 1;
    tick();
    host_sel = 0;
  endtask

  task automatic sbit(bit pull);
    ext_low = pull; sclk = 0;
    tick(); tick();
    sclk = 1;
    tick(); tick();
    ext_low = 0;
  endtask

  task automatic sbyte(logic [7:0] others);
    for (int i = 7; i >= 0; i--) sbit(!others[i]);
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", host_rdata, 8'h00);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 line", {7'd0, sdata_drive_low}, 8'd0);
    rst_n = 1;
    tick();

    hwrite(1, 8'hA5);
    host_sel = 1; tick();
    chk("R2 address read", host_rdata, 8'hA5);
    host_sel = 0;
    hwrite(0, 8'hA5);
    irq_seen = 0;
    sbyte(8'hFF);
    chk("R9 clean send match", {7'd0, match}, 8'd1);
    chk("R7 one irq", irq_seen[7:0], 8'd1);

    hwrite(0, 8'hA5);
    for (int i = 7; i >= 1; i--) sbit(0);
    sbit(1);
    tick();
    chk("R9 conflict read-back", host_rdata, 8'hA4);
    chk("R9 conflict no match", {7'd0, match}, 8'd0);

    wake_en = 1;
    bus_rel = 1; tick();
    hwrite(0, 8'hFF);
    irq_seen = 0;
    sbyte(8'hA5);
    chk("R8 addressed irq", irq_seen[7:0], 8'd1);
    chk("R8 received byte", host_rdata, 8'hA5);

    hwrite(0, 8'hFF);
    irq_seen = 0;
    sbyte(8'hA5);
    chk("R8 no release no irq", irq_seen[7:0], 8'd0);

    bus_rel = 1; tick();
    hwrite(0, 8'hFF);
    irq_seen = 0;
    sbyte(8'h3C);
    chk("R8 wrong address no irq", irq_seen[7:0], 8'd0);

    wake_en = 0;
    for (int i = 0; i < 4; i++) sbit(1);
    chk("R10 idle unchanged", host_rdata, 8'h3C);

    hwrite(0, 8'h5A);
    for (int i = 0; i < 4; i++) sbit(0);
    chk("R4 partial read", host_rdata, 8'hA5);
    chk("R5 still busy", {7'd0, busy}, 8'd1);
    hwrite(0, 8'hC3);
    irq_seen = 0;
    for (int i = 0; i < 4; i++) sbit(0);
    chk("R2 restart busy", {7'd0, busy}, 8'd1);
    for (int i = 0; i < 4; i++) sbit(0);
    tick();
    chk("R2 restart result", host_rdata, 8'hC3);
    chk("R7 restart irq", irq_seen[7:0], 8'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule